// File: doc/BRIEF.md
# Host-Visible Shared Register Bank with Two-Way Interrupts

This block is the byte-addressed register window that a card-bus host reaches through the single-register and burst accesses of function 1. Part of the window is a set of 8-bit mailbox registers shared between the host and the local slave logic. These registers sit in several separate address ranges, with unmapped gaps between them. The rest of the window holds the interrupt machinery for both directions.

In the slave-to-host direction, local logic raises sources into a status byte. The host masks that byte with an enable byte and clears it by writing ones. An active-low level output reports any pending, unmasked source, and is meant to drive the interrupt data line. In the host-to-slave direction, the host writes a trigger byte. Every bit that rises there produces a one-cycle event pulse on the local side, and the byte then empties itself.

The host port has an address, write data, a write strobe and combinational read data. The local port addresses the shared registers by register number and has its own input for raising sources. Command parsing and the bulk data windows are outside this block.

Top module: `hostlink_regbank`

## Requirements
- R1: After reset, every shared register, the status byte, the enable byte and the trigger byte read 0, `irq_n` is 1, and `h2s_evt` is 0.
- R2: A host write lands in the shared register that its offset maps to, and the value becomes visible on the following cycle at both ports. The mapping from offset to register number is: 0x06C–0x077 → offset−0x06C (registers 0–11); 0x07A–0x07B and 0x07E–0x07F → offset−0x06C (registers 14–15 and 18–19); 0x088–0x08B → offset−0x070 (registers 24–27); 0x09C–0x0BB → offset−0x07C (registers 32–63).
- R3: The slave port writes the shared register selected by `s_idx`. If the host and the slave write the same register in the same cycle, the register takes the host value.
- R4: Any offset that is neither a shared register nor one of the four interrupt offsets reads 0 and ignores writes. This covers the gaps and the upper bytes of the interrupt words. A slave index of an unmapped register number reads 0 and ignores writes.
- R5: Bit i of `s_irq_set` sets bit i of the status byte, which the host reads at offset 0x058 one cycle later. Host writes to 0x058 have no effect.
- R6: A host write to 0x0D4 clears every status bit written as 1. A source raised in the same cycle as its clear stays set.
- R7: The enable byte is written and read at 0x0DC. `irq_n` is 0 exactly while some status bit and its enable bit are both 1, and it follows the registered state with no extra delay.
- R8: A host write to 0x08D loads the trigger byte. On the next cycle, `h2s_evt` pulses for one cycle on each bit that was 0 and is written 1, and 0x08D reads the written value. The byte reads 0 from the cycle after that, unless it is written again.
- R9: A trigger bit that is still 1 from a write in the previous cycle produces no event when it is written 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | ADDR_W | Host byte offset |
| h_wdata | input | 8 | Host write data |
| h_wr | input | 1 | Host write strobe |
| h_rdata | output | 8 | Host read data for `h_addr` |
| s_idx | input | IDX_W | Slave shared register number |
| s_wdata | input | 8 | Slave write data |
| s_wr | input | 1 | Slave write strobe |
| s_rdata | output | 8 | Slave read data for `s_idx` |
| s_irq_set | input | IRQ_W | Slave-to-host sources to raise |
| h2s_evt | output | IRQ_W | Host-to-slave event pulses |
| irq_n | output | 1 | Active-low level interrupt to host |

## Verification
The assertions assume that all inputs are stable for the whole cycle around each rising edge and that reset is held for at least one edge. They also assume that at most one host access is presented per cycle, and that `s_irq_set` may be high in any cycle, including the cycle in which the same bit is cleared. The stimulus changes every input a fixed delay after the rising edge and returns the strobes and source inputs to 0 at each step. Collisions are only ever created on purpose: one shared-register collision, one set-with-clear, and back-to-back trigger writes.

// File: rtl/hlrb_pkg.sv
package hlrb_pkg;
  localparam int MAP_AW = 12;
  localparam logic [MAP_AW-1:0] OFF_STAT = 12'h058;
  localparam logic [MAP_AW-1:0] OFF_CLR  = 12'h0D4;
  localparam logic [MAP_AW-1:0] OFF_ENA  = 12'h0DC;
  localparam logic [MAP_AW-1:0] OFF_TRIG = 12'h08D;

  typedef struct packed {
    logic       hit;
    logic [5:0] idx;
  } map_t;

  // offset -> shared register number
  function automatic map_t shared_map(input logic [MAP_AW-1:0] a);
    map_t m;
    m.hit = 1'b0;
    m.idx = '0;
    if ((a >= 12'h06C && a <= 12'h077) || a == 12'h07A || a == 12'h07B ||
        a == 12'h07E || a == 12'h07F) begin
      m.hit = 1'b1;
      m.idx = 6'(a - 12'h06C);
    end else if (a >= 12'h088 && a <= 12'h08B) begin
      m.hit = 1'b1;
      m.idx = 6'(a - 12'h070);
    end else if (a >= 12'h09C && a <= 12'h0BB) begin
      m.hit = 1'b1;
      m.idx = 6'(a - 12'h07C);
    end
    return m;
  endfunction

  // register numbers that physically exist
  function automatic logic idx_mapped(input int unsigned i);
    return (i <= 11) || (i == 14) || (i == 15) || (i == 18) || (i == 19) ||
           (i >= 24 && i <= 27) || (i >= 32 && i <= 63);
  endfunction
endpackage

// File: rtl/hlrb_decode.sv
module hlrb_decode
  import hlrb_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_shared,
  output logic [IDX_W-1:0]  sh_idx,
  output logic              sel_stat,
  output logic              sel_clr,
  output logic              sel_ena,
  output logic              sel_trig
);
  logic [MAP_AW-1:0] a_ext;
  map_t              m;

  assign a_ext      = MAP_AW'(addr);
  assign m          = shared_map(a_ext);
  assign sel_shared = m.hit;
  assign sh_idx     = IDX_W'(m.idx);
  assign sel_stat   = (a_ext == OFF_STAT);
  assign sel_clr    = (a_ext == OFF_CLR);
  assign sel_ena    = (a_ext == OFF_ENA);
  assign sel_trig   = (a_ext == OFF_TRIG);
endmodule

// File: rtl/hlrb_shared.sv
module hlrb_shared
  import hlrb_pkg::*;
#(
  parameter int NREG  = 64,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_we,
  input  logic [IDX_W-1:0] h_idx,
  input  logic [7:0]       h_wdata,
  output logic [7:0]       h_rdata,
  input  logic             s_we,
  input  logic [IDX_W-1:0] s_idx,
  input  logic [7:0]       s_wdata,
  output logic [7:0]       s_rdata
);
  logic [NREG-1:0][7:0] regs;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (idx_mapped(i)) begin : g_live
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                 q <= '0;
        else if (h_we && h_idx == IDX_W'(i))        q <= h_wdata;  // host has priority
        else if (s_we && s_idx == IDX_W'(i))        q <= s_wdata;
      end
      assign regs[i] = q;
    end else begin : g_hole
      assign regs[i] = '0;
    end
  end

  assign h_rdata = regs[h_idx];
  assign s_rdata = regs[s_idx];

  // R3: simultaneous writes to one register keep the host value
  a_r3_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && s_we && h_idx == s_idx) |=> (regs[$past(h_idx)] == $past(h_wdata)));

  // R4: a register number with no storage always reads zero
  a_r4_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_mapped(32'(s_idx)) |-> (s_rdata == 8'h00));
endmodule

// File: rtl/hlrb_irq_s2h.sv
module hlrb_irq_s2h #(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_mask,
  input  logic             en_we,
  input  logic [IRQ_W-1:0] en_wdata,
  output logic [IRQ_W-1:0] status,
  output logic [IRQ_W-1:0] enable,
  output logic             irq_n
);
  logic [IRQ_W-1:0] clr_eff;
  logic [IRQ_W-1:0] pending;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~clr_eff) | set;  // a new source beats its clear
      if (en_we) enable <= en_wdata;
    end
  end

  assign pending = status & enable;
  assign irq_n   = ~|pending;

  // R6: raised sources are present next cycle, even with a clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((status & $past(set)) == $past(set)));

  // R6: cleared bits that were not re-raised are gone
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (clr_mask & ~set) != '0) |=> ((status & $past(clr_mask & ~set)) == '0));

  // R7: enabling a set source pulls the line low
  a_r7_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && !clr_we && ((status | set) & en_wdata) != '0) |=> !irq_n);

  // R7: no status means the line is idle
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> irq_n);
endmodule

// File: rtl/hlrb_irq_h2s.sv
module hlrb_irq_h2s #(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IRQ_W-1:0] wdata,
  output logic [IRQ_W-1:0] trig,
  output logic [IRQ_W-1:0] evt
);
  logic [IRQ_W-1:0] rising;

  assign rising = wdata & ~trig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig <= '0;
      evt  <= '0;
    end else begin
      trig <= we ? wdata  : '0;  // self-clearing after one cycle
      evt  <= we ? rising : '0;
    end
  end

  // R8: without a write the trigger byte empties
  a_r8_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (trig == '0));

  // R8: events only follow a host write
  a_r8_evt_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |-> $past(we));

  // R9: bits already high give no event
  a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((evt & $past(trig)) == '0));
endmodule

// File: rtl/hostlink_regbank.sv
module hostlink_regbank
  import hlrb_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int IRQ_W  = 8,
  parameter int NREG   = 64,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [7:0]        h_wdata,
  input  logic              h_wr,
  output logic [7:0]        h_rdata,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic [7:0]        s_wdata,
  input  logic              s_wr,
  output logic [7:0]        s_rdata,
  input  logic [IRQ_W-1:0]  s_irq_set,
  output logic [IRQ_W-1:0]  h2s_evt,
  output logic              irq_n
);
  logic             sel_shared, sel_stat, sel_clr, sel_ena, sel_trig;
  logic [IDX_W-1:0] sh_idx;
  logic             sh_we, clr_we, ena_we, trig_we;
  logic [7:0]       sh_hrd;
  logic [IRQ_W-1:0] status, enable, trig;

  hlrb_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(h_addr), .sel_shared(sel_shared), .sh_idx(sh_idx),
    .sel_stat(sel_stat), .sel_clr(sel_clr), .sel_ena(sel_ena), .sel_trig(sel_trig)
  );

  assign sh_we   = h_wr & sel_shared;
  assign clr_we  = h_wr & sel_clr;
  assign ena_we  = h_wr & sel_ena;
  assign trig_we = h_wr & sel_trig;

  hlrb_shared #(.NREG(NREG), .IDX_W(IDX_W)) u_sh (
    .clk(clk), .rst_n(rst_n),
    .h_we(sh_we), .h_idx(sh_idx), .h_wdata(h_wdata), .h_rdata(sh_hrd),
    .s_we(s_wr), .s_idx(s_idx), .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  hlrb_irq_s2h #(.IRQ_W(IRQ_W)) u_s2h (
    .clk(clk), .rst_n(rst_n), .set(s_irq_set),
    .clr_we(clr_we), .clr_mask(h_wdata[IRQ_W-1:0]),
    .en_we(ena_we), .en_wdata(h_wdata[IRQ_W-1:0]),
    .status(status), .enable(enable), .irq_n(irq_n)
  );

  hlrb_irq_h2s #(.IRQ_W(IRQ_W)) u_h2s (
    .clk(clk), .rst_n(rst_n), .we(trig_we), .wdata(h_wdata[IRQ_W-1:0]),
    .trig(trig), .evt(h2s_evt)
  );

  always_comb begin
    h_rdata = 8'h00;
    if (sel_shared)    h_rdata = sh_hrd;
    else if (sel_stat) h_rdata = 8'(status);
    else if (sel_ena)  h_rdata = 8'(enable);
    else if (sel_trig) h_rdata = 8'(trig);
  end

  // R5: host writes cannot touch the status byte
  a_r5_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && sel_stat && s_irq_set == '0 && !clr_we) |=> $stable(status));

  // R4: unmapped offsets read zero
  a_r4_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_shared || sel_stat || sel_ena || sel_trig) |-> (h_rdata == 8'h00));
endmodule

// File: tb/hostlink_regbank_test.sv
module hostlink_regbank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] h_addr = '0;
  logic [7:0] h_wdata = '0;
  logic       h_wr = 1'b0;
  logic [7:0] h_rdata;
  logic [5:0] s_idx = '0;
  logic [7:0] s_wdata = '0;
  logic       s_wr = 1'b0;
  logic [7:0] s_rdata;
  logic [7:0] s_irq_set = '0;
  logic [7:0] h2s_evt;
  logic       irq_n;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  localparam int K_HOST = 0, K_SLV = 1, K_IRQ = 2, K_EVT = 3;

  typedef struct {
    int         at;
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  logic [7:0] model [64];

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  hostlink_regbank uut (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wdata(h_wdata), .h_wr(h_wr),
    .h_rdata(h_rdata), .s_idx(s_idx), .s_wdata(s_wdata), .s_wr(s_wr),
    .s_rdata(s_rdata), .s_irq_set(s_irq_set), .h2s_evt(h2s_evt), .irq_n(irq_n)
  );

  // bench view of the offset map, written as a list of windows
  function automatic int ref_idx(input int a);
    int lo[5]   = '{'h06C, 'h07A, 'h07E, 'h088, 'h09C};
    int hi[5]   = '{'h077, 'h07B, 'h07F, 'h08B, 'h0BB};
    int base[5] = '{0, 14, 18, 24, 32};
    for (int w = 0; w < 5; w++)
      if (a >= lo[w] && a <= hi[w]) return base[w] + (a - lo[w]);
    return -1;
  endfunction

  function automatic logic ref_live(input int i);
    for (int a = 'h06C; a <= 'h0BB; a++)
      if (ref_idx(a) == i) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] observe(input int kind);
    case (kind)
      K_HOST:  return h_rdata;
      K_SLV:   return s_rdata;
      K_IRQ:   return {7'b0, irq_n};
      default: return h2s_evt;
    endcase
  endfunction

  // monitor: compare queued expectations in the middle of their cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      item_t it;
      logic [7:0] act;
      it  = sb.pop_front();
      act = observe(it.kind);
      n_chk++;
      if (it.at != cyc || act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind %0d: actual %h expected %h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    h_wr = 1'b0;
    s_wr = 1'b0;
    s_irq_set = '0;
  endtask

  task automatic expect_now(input int kind, input logic [7:0] e, input string req);
    item_t it;
    it.at = cyc; it.kind = kind; it.exp = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic hwrite(input int a, input logic [7:0] d);
    h_addr = 9'(a); h_wdata = d; h_wr = 1'b1;
    if (ref_idx(a) >= 0) model[ref_idx(a)] = d;
  endtask

  task automatic hread(input int a, input logic [7:0] e, input string req);
    h_addr = 9'(a);
    expect_now(K_HOST, e, req);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    step(); hread('h058, 8'h00, "R1"); expect_now(K_IRQ, 8'h01, "R1"); expect_now(K_EVT, 8'h00, "R1");
    step(); hread('h0DC, 8'h00, "R1"); s_idx = 6'd40; expect_now(K_SLV, 8'h00, "R1");
    step(); hread('h08D, 8'h00, "R1");

    // R2 / R4 sweep: write every offset, mapped or not
    for (int a = 'h060; a <= 'h0C0; a++) begin
      if (a == 'h08D) continue;
      step(); hwrite(a, 8'(a) ^ 8'hA5);
    end
    for (int a = 'h060; a <= 'h0C0; a++) begin
      if (a == 'h08D) continue;
      step();
      if (ref_idx(a) >= 0) hread(a, model[ref_idx(a)], "R2");
      else                 hread(a, 8'h00, "R4");
    end
    for (int i = 0; i < 64; i++) begin
      step(); s_idx = 6'(i);
      expect_now(K_SLV, ref_live(i) ? model[i] : 8'h00, ref_live(i) ? "R2" : "R4");
    end
    // R4 upper bytes of interrupt words and slave writes to holes
    step(); hwrite('h059, 8'hFF);
    step(); hread('h059, 8'h00, "R4"); s_wr = 1'b1; s_idx = 6'd12; s_wdata = 8'h77;
    step(); s_idx = 6'd12; expect_now(K_SLV, 8'h00, "R4"); hread('h058, 8'h00, "R4");

    // R3 slave write, then same-register collision
    step(); s_wr = 1'b1; s_idx = 6'd5; s_wdata = 8'h3C;
    step(); hread('h071, 8'h3C, "R3");
    step(); hwrite('h09D, 8'h11); s_wr = 1'b1; s_idx = 6'd33; s_wdata = 8'h22;
    step(); hread('h09D, 8'h11, "R3"); s_idx = 6'd33; expect_now(K_SLV, 8'h11, "R3");

    // R5 raise sources, host cannot write status
    step(); s_irq_set = 8'h05;
    step(); hread('h058, 8'h05, "R5"); expect_now(K_IRQ, 8'h01, "R7");
    step(); hwrite('h058, 8'hFF);
    step(); hread('h058, 8'h05, "R5");

    // R7 enable one source
    step(); hwrite('h0DC, 8'h01);
    step(); expect_now(K_IRQ, 8'h00, "R7"); hread('h0DC, 8'h01, "R7");

    // R6 clear, and set-with-clear
    step(); hwrite('h0D4, 8'h01);
    step(); hread('h058, 8'h04, "R6"); expect_now(K_IRQ, 8'h01, "R7");
    step(); hwrite('h0D4, 8'h04); s_irq_set = 8'h04;
    step(); hread('h058, 8'h04, "R6");
    step(); hwrite('h0DC, 8'h04);
    step(); expect_now(K_IRQ, 8'h00, "R7");
    step(); hwrite('h0D4, 8'h04);
    step(); expect_now(K_IRQ, 8'h01, "R6"); hread('h058, 8'h00, "R6");

    // R8 trigger pulse and self clear
    step(); hwrite('h08D, 8'h03);
    step(); hread('h08D, 8'h03, "R8"); expect_now(K_EVT, 8'h03, "R8");
    step(); hread('h08D, 8'h00, "R8"); expect_now(K_EVT, 8'h00, "R8");

    // R9 back-to-back trigger writes
    step(); hwrite('h08D, 8'h01);
    step(); expect_now(K_EVT, 8'h01, "R9"); hwrite('h08D, 8'h01);
    step(); expect_now(K_EVT, 8'h00, "R9"); hwrite('h08D, 8'h07);
    step(); expect_now(K_EVT, 8'h06, "R9"); hread('h08D, 8'h07, "R9");
    step(); expect_now(K_EVT, 8'h00, "R8");

    step(); step();
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule